// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple clocked request port and an external asynchronous static RAM. The RAM has an 18-bit word address, a 16-bit data bus split into two 8-bit lanes, and active-low chip, output, write and per-lane enables. A host raises `req` while `ready` is high and supplies a direction flag, a two-bit lane mask, an address and write data. The controller then steps through fixed-length phases to run the memory cycle. A read ends with the captured word on `rdata` and a one-cycle `rvalid` pulse.

Phase lengths come from parameters: the clock period and the memory's access, output-enable, cycle, write-pulse and data-setup times, all in picoseconds. Each phase lasts ceil(time / period) clocks, and never less than one clock. A write takes place only while chip enable, write strobe and at least one lane enable are all low. The controller opens and closes that window with the lane enables, and it changes address and data only while the window is closed.

When the `hold_we` mode input is high, the write strobe stays low between back-to-back write requests. In that mode the lane enables alone open and close each word write.

Top module: `sram_lane_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready`=1, `rvalid`=0, `mem_dq_oe`=0, and `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n`, `mem_lb_n` are all 1.
- R2: A read drives `mem_ce_n`=0, `mem_we_n`=1 and `mem_oe_n`=0, and pulls low only the lane enables selected in `be`. `be[1]` selects bits 15..8 through `mem_ub_n`, and `be[0]` selects bits 7..0 through `mem_lb_n`. The returned word holds the memory's data on the selected lanes.
- R3: `mem_oe_n` is never low while `mem_we_n` is low.
- R4: A memory write (chip, write strobe and a lane enable all low) happens only while `mem_dq_oe`=1. `mem_addr` and `mem_dq_o` stay constant for as long as the write window is open. A lane not selected in `be` keeps its stored value.
- R5: `mem_oe_n` goes low only when `mem_dq_oe` has been 0 in that cycle and in the cycle before, so the two never drive the bus together.
- R6: A read accepted at clock edge k raises `rvalid` after edge k+1+NR, where NR = ceil(max(tAA,tRC,tOE)/period) (2 at the defaults). `rvalid` stays high for exactly one cycle.
- R7: A write accepted at edge k returns `ready` high after edge k+1+NW+NE. Here NW = ceil(max(tWP,tDS)/period) and NE = max(1, ceil(tWC/period)−NW−1), both at least 1 (1 and 1 at the defaults).
- R8: Lanes not selected in `be` read back as zero in `rdata`, whatever the memory drives on them.
- R9: A request with `be`=2'b00 completes one edge after acceptance without pulling `mem_ce_n` low. If it was a read, it gives an `rvalid` pulse with `rdata`=0.
- R10: `ready` is low from the edge that accepts a request until the cycle completes.
- R11: With `hold_we`=1, `mem_we_n` stays low from the first write pulse through back-to-back write requests, and rises once, in the first idle cycle without a further write. Each word is still written correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_we | input | 1 | Keep write strobe low across back-to-back writes |
| req | input | 1 | Host request, taken when `ready` is high |
| ready | output | 1 | Controller idle and able to accept |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Lane select, bit 1 upper, bit 0 lower |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, unselected lanes zero |
| rvalid | output | 1 | One-cycle read-complete strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_i | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Enables the data-bus driver |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |

## Verification
Each transaction's result is timed from its accepting edge. At the defaults, `rvalid` and `ready` return in the fourth falling-edge sample after that edge for reads and writes, and in the second for empty-mask requests. The bench derives these counts from the same ceiling formulas the requirements state, not from the RTL. It counts falling edges from acceptance and compares the count, and samples `rdata` in the same half-cycle. A memory model on the far side records write windows, bus contention and write-strobe rising edges cycle by cycle, so each hold-mode and lane-masking result is checked against the memory contents and those counters.

// File: rtl/sram_lane_ctl_pkg.sv
package sram_lane_ctl_pkg;

    localparam int unsigned LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NULL,
        ST_RSETUP,
        ST_RACCESS,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOVER
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } mem_ctl_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned clocks_for(input int unsigned t_ps, input int unsigned per_ps);
        int unsigned n;
        n = (t_ps + per_ps - 1) / per_ps;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));

    // R7: every phase is at least one clock long
    a_r7_nonzero_phase: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    // R7: a running phase counts down by one per clock
    a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_lane_unit.sv
module sram_lane_unit #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        sel,
    input  logic                    strobe_on,
    input  logic                    capture,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES-1:0]        lane_n,
    output logic [LANES*LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] cap_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = !(strobe_on && sel[g]);
        assign rdata[g*LANE_W +: LANE_W] = cap_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q[g] <= '0;
            end else if (capture) begin
                cap_q[g] <= sel[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
            end
        end

        // R8: an unselected lane captures zero
        a_r8_unselected_zero: assert property (@(posedge clk) disable iff (rst)
            (capture && !sel[g]) |=> (cap_q[g] == '0));
    end

endmodule

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl
    import sram_lane_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CLK_PS   = 8000,
    parameter int unsigned T_AA_PS  = 10000,
    parameter int unsigned T_OE_PS  = 4000,
    parameter int unsigned T_RC_PS  = 10000,
    parameter int unsigned T_WC_PS  = 10000,
    parameter int unsigned T_WP_PS  = 8000,
    parameter int unsigned T_DS_PS  = 6000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_we,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [1:0]        be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);

    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned N_RD   = clocks_for(umax(umax(T_AA_PS, T_RC_PS), T_OE_PS), CLK_PS);
    localparam int unsigned N_WP   = clocks_for(umax(T_WP_PS, T_DS_PS), CLK_PS);
    localparam int unsigned N_WC   = clocks_for(T_WC_PS, CLK_PS);
    localparam int unsigned N_WR   = (N_WC > N_WP + 1) ? (N_WC - N_WP - 1) : 1;
    localparam int unsigned CNT_W  = $clog2(umax(N_RD, umax(N_WP, N_WR)) + 1);
    localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD);
    localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP);
    localparam logic [CNT_W-1:0] LD_WR = CNT_W'(N_WR);

    phase_e              st_q;
    logic                wr_q;
    logic [LANES-1:0]    be_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                we_held_q;
    logic                rvalid_q;

    logic                t_load;
    logic [CNT_W-1:0]    t_val;
    logic                t_last;
    logic                lane_strobe;
    logic                capture;
    logic [LANES-1:0]    lane_n;
    logic                accept;
    logic                chain_write;
    mem_ctl_t            ctl;

    assign accept      = (st_q == ST_IDLE) && req;
    assign chain_write = req && wr && (be != '0) && hold_we;

    // phase timer control
    always_comb begin
        t_load = 1'b0;
        t_val  = LD_RD;
        case (st_q)
            ST_RSETUP: begin t_load = 1'b1; t_val = LD_RD; end
            ST_WSETUP: begin t_load = 1'b1; t_val = LD_WP; end
            ST_WPULSE: begin t_load = t_last; t_val = LD_WR; end
            default:   ;
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            wr_q      <= 1'b0;
            be_q      <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            we_held_q <= 1'b0;
            rvalid_q  <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req) begin
                        wr_q    <= wr;
                        be_q    <= be;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        if (be == '0)  st_q <= ST_NULL;
                        else if (wr)   st_q <= ST_WSETUP;
                        else           st_q <= ST_RSETUP;
                    end
                    if (we_held_q && !chain_write) we_held_q <= 1'b0;
                end
                ST_NULL: begin
                    rvalid_q <= !wr_q;
                    st_q     <= ST_IDLE;
                end
                ST_RSETUP:  st_q <= ST_RACCESS;
                ST_RACCESS: begin
                    if (t_last) begin
                        rvalid_q <= 1'b1;
                        st_q     <= ST_IDLE;
                    end
                end
                ST_WSETUP:  st_q <= ST_WPULSE;
                ST_WPULSE: begin
                    if (t_last) begin
                        we_held_q <= hold_we;
                        st_q      <= ST_WRECOVER;
                    end
                end
                ST_WRECOVER: begin
                    if (t_last) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // memory-side control decode
    always_comb begin
        ctl.ce_n = !((st_q inside {ST_RSETUP, ST_RACCESS, ST_WSETUP, ST_WPULSE, ST_WRECOVER})
                     || (st_q == ST_IDLE && we_held_q));
        ctl.oe_n = !(st_q == ST_RACCESS);
        ctl.we_n = !((st_q == ST_WPULSE)
                     || (we_held_q && (st_q inside {ST_IDLE, ST_WSETUP, ST_WRECOVER})));
    end

    assign lane_strobe = (st_q == ST_RACCESS) || (st_q == ST_WPULSE);
    assign capture     = ((st_q == ST_RACCESS) && t_last) || (st_q == ST_NULL);

    sram_lane_unit #(.LANES(LANES), .LANE_W(LANE_W)) i_lanes (
        .clk       (clk),
        .rst       (rst),
        .sel       (be_q),
        .strobe_on (lane_strobe),
        .capture   (capture),
        .dq_i      (mem_dq_i),
        .lane_n    (lane_n),
        .rdata     (rdata)
    );

    assign ready     = (st_q == ST_IDLE);
    assign rvalid    = rvalid_q;
    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign mem_dq_oe = st_q inside {ST_WSETUP, ST_WPULSE, ST_WRECOVER};
    assign mem_ce_n  = ctl.ce_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_ub_n  = lane_n[LANES-1];
    assign mem_lb_n  = lane_n[0];

    logic wr_window;
    assign wr_window = !mem_ce_n && !mem_we_n && (!mem_ub_n || !mem_lb_n);

    a_r3_read_not_write: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    a_r4_window_driven: assert property (@(posedge clk) disable iff (rst)
        wr_window |-> mem_dq_oe);

    a_r4_window_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_window && $past(wr_window)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));

    a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    a_r9_null_no_select: assert property (@(posedge clk) disable iff (rst)
        (accept && be == '0) |=> mem_ce_n);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

endmodule

// File: tb/test_sram_lane_ctl.sv
`timescale 1ns/1ps
module test_sram_lane_ctl;

    localparam int unsigned AW = 18;
    localparam int unsigned DW = 16;
    localparam int unsigned PER = 8000;
    // expected phase counts from the requirement formulas
    localparam int unsigned NR = (10000 + PER - 1) / PER;
    localparam int unsigned NW = (8000 + PER - 1) / PER;
    localparam int unsigned NC = (10000 + PER - 1) / PER;
    localparam int unsigned NE = (NC > NW + 1) ? NC - NW - 1 : 1;
    localparam int unsigned LAT_RD = NR + 2;
    localparam int unsigned LAT_WR = NW + NE + 2;
    localparam int unsigned LAT_NULL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_we = 1'b0;
    logic req = 1'b0;
    logic wr = 1'b0;
    logic [1:0] be = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic ready, rvalid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [DW-1:0] rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    always #4 clk = ~clk;

    sram_lane_ctl i_sram_lane_ctl (
        .clk(clk), .rst(rst), .hold_we(hold_we), .req(req), .ready(ready),
        .wr(wr), .be(be), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
        .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
    );

    // memory model: 64 words indexed by the low address bits
    logic [15:0] sram [64];
    int n_contend = 0, n_undriven = 0, n_we_rise = 0, n_ce_low = 0;
    logic we_prev = 1'b1;
    logic rd_on;
    assign rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_i = {(rd_on && !mem_ub_n) ? sram[mem_addr[5:0]][15:8] : 8'hA5,
                       (rd_on && !mem_lb_n) ? sram[mem_addr[5:0]][7:0]  : 8'h5A};

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) sram[i] <= 16'h0000;
            we_prev <= 1'b1;
        end else begin
            if (!mem_ce_n && !mem_we_n) begin
                if (!mem_lb_n) sram[mem_addr[5:0]][7:0]  <= mem_dq_o[7:0];
                if (!mem_ub_n) sram[mem_addr[5:0]][15:8] <= mem_dq_o[15:8];
                if ((!mem_lb_n || !mem_ub_n) && !mem_dq_oe) n_undriven++;
            end
            if (!mem_oe_n && mem_dq_oe) n_contend++;
            if (mem_we_n && !we_prev) n_we_rise++;
            if (!mem_ce_n) n_ce_low++;
            we_prev <= mem_we_n;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int lat;
    logic [DW-1:0] rd_word;
    logic rv;
    logic busy_seen;

    // called at a falling edge with ready high; returns at the falling edge where ready is back
    task automatic txn(input logic w, input logic [1:0] m, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        req = 1'b1; wr = w; be = m; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        busy_seen = !ready;
        while (!ready && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        rv = rvalid;
        rd_word = rdata;
    endtask

    typedef struct packed {
        logic          w;
        logic [1:0]    m;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [DW-1:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b11, 18'h00003, 16'h1234, 16'h0000},
        '{1'b0, 2'b11, 18'h00003, 16'h0000, 16'h1234},
        '{1'b1, 2'b01, 18'h00003, 16'hABCD, 16'h0000},
        '{1'b0, 2'b11, 18'h00003, 16'h0000, 16'h12CD},
        '{1'b1, 2'b10, 18'h00005, 16'h5566, 16'h0000},
        '{1'b0, 2'b01, 18'h00005, 16'h0000, 16'h0000},
        '{1'b0, 2'b10, 18'h00005, 16'h0000, 16'h5500},
        '{1'b1, 2'b11, 18'h3FFC0, 16'hFFFF, 16'h0000},
        '{1'b0, 2'b11, 18'h3FFC0, 16'h0000, 16'hFFFF},
        '{1'b0, 2'b10, 18'h00003, 16'h0000, 16'h1200}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    int r0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(ready && !rvalid && !mem_dq_oe && mem_ce_n && mem_oe_n && mem_we_n
            && mem_ub_n && mem_lb_n, "R1 reset state", {ready, mem_ce_n, mem_oe_n, mem_we_n}, 4'hF);
        rst = 1'b0;
        @(negedge clk);
        chk(ready && !rvalid && mem_ce_n && mem_we_n, "R1 after reset", {ready, mem_ce_n}, 2'b11);

        // table walk: R2 R4 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            txn(VEC[i].w, VEC[i].m, VEC[i].a, VEC[i].d);
            chk(busy_seen, "R10 busy after accept", busy_seen, 1);
            if (VEC[i].w) begin
                chk(lat == LAT_WR, "R7 write latency", lat, LAT_WR);
                chk(!rv, "R6 no rvalid on write", rv, 0);
            end else begin
                chk(lat == LAT_RD, "R6 read latency", lat, LAT_RD);
                chk(rv, "R6 rvalid at completion", rv, 1);
                chk(rd_word == VEC[i].exp, "R2 R4 R8 read data", rd_word, VEC[i].exp);
                @(negedge clk);
                chk(!rvalid, "R6 rvalid single cycle", rvalid, 0);
            end
        end

        // R9: empty-mask write and read
        r0 = n_ce_low;
        txn(1'b1, 2'b00, 18'h00003, 16'hDEAD);
        chk(lat == LAT_NULL, "R9 null write latency", lat, LAT_NULL);
        chk(n_ce_low == r0, "R9 no chip select on null write", n_ce_low - r0, 0);
        txn(1'b0, 2'b00, 18'h00003, 16'h0000);
        chk(lat == LAT_NULL && rv && rd_word == 16'h0000, "R9 null read", {rv, rd_word}, 17'h10000);
        chk(n_ce_low == r0, "R9 no chip select on null read", n_ce_low - r0, 0);
        txn(1'b0, 2'b11, 18'h00003, 16'h0000);
        chk(rd_word == 16'h12CD, "R9 null write left memory intact", rd_word, 16'h12CD);

        // R11: hold mode, three back-to-back writes
        hold_we = 1'b1;
        r0 = n_we_rise;
        txn(1'b1, 2'b11, 18'h0000A, 16'hA0A0);
        chk(!mem_we_n && !mem_ce_n, "R11 strobe held in idle", mem_we_n, 0);
        txn(1'b1, 2'b01, 18'h0000B, 16'hB1B1);
        chk(lat == LAT_WR, "R11 held write latency", lat, LAT_WR);
        txn(1'b1, 2'b10, 18'h0000C, 16'hC2C2);
        chk(n_we_rise == r0, "R11 no strobe rise between words", n_we_rise - r0, 0);
        @(negedge clk);
        @(negedge clk);
        chk(n_we_rise == r0 + 1 && mem_we_n, "R11 single release", n_we_rise - r0, 1);
        hold_we = 1'b0;
        txn(1'b0, 2'b11, 18'h0000A, 16'h0);
        chk(rd_word == 16'hA0A0, "R11 word A", rd_word, 16'hA0A0);
        txn(1'b0, 2'b11, 18'h0000B, 16'h0);
        chk(rd_word == 16'h00B1, "R11 word B", rd_word, 16'h00B1);
        txn(1'b0, 2'b11, 18'h0000C, 16'h0);
        chk(rd_word == 16'hC200, "R11 word C", rd_word, 16'hC200);

        // R11 followed directly by a read: strobe released before the read
        hold_we = 1'b1;
        txn(1'b1, 2'b11, 18'h0000D, 16'h7E7E);
        txn(1'b0, 2'b11, 18'h0000D, 16'h0);
        chk(rv && rd_word == 16'h7E7E, "R11 R2 read after held write", rd_word, 16'h7E7E);
        hold_we = 1'b0;

        // R7: without hold, each write releases the strobe
        r0 = n_we_rise;
        txn(1'b1, 2'b11, 18'h00010, 16'h1111);
        txn(1'b1, 2'b11, 18'h00011, 16'h2222);
        chk(n_we_rise == r0 + 2, "R7 strobe per write", n_we_rise - r0, 2);

        // R4 R5 R3: bus monitors
        chk(n_contend == 0, "R5 bus contention", n_contend, 0);
        chk(n_undriven == 0, "R4 write without data drive", n_undriven, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule